// File: doc/BRIEF.md
# Keypad Interrupt and Mask Controller

This block keeps track of which of sixteen keys are currently held, and raises an active-low keypad interrupt when a key that is not masked goes down. Keys reach it as single events, each carrying a key index and a press or release flag. At most one event is accepted per clock. Matrix scanning and debounce timing happen elsewhere; only the debounce setting is held here.

Software reaches the block through four 16-bit registers, selected by a 2-bit address. They hold the key bitmap, the scan and debounce control, the interrupt mode and the key mask. Two mode bits decide how a pending interrupt goes away. With the hold bit clear, it clears once every unmasked key is released. With the clear-on-read bit set, a read of the key bitmap acknowledges it. In every mode, a control write with the scan bit set clears it.

Register reads are combinational on `rd_data` for the address presented. Their side effects, like all state changes, take effect at the next rising clock edge.

Top module: `keypad_irq_ctrl`

## Requirements
- R1: A press event for key k sets bit k of the held bitmap and a release event clears it. The bitmap is read at address 0. A write to address 0 changes nothing.
- R2: A press event that leaves at least one unmasked key held, with no interrupt pending, sets the interrupt. `kbd_irq_n` then goes low after that clock edge. A press of a key whose mask bit is 1, with no other unmasked key held, raises nothing.
- R3: With mode bit 0 clear (the hold bit), a key event that leaves no unmasked key held clears a pending interrupt. With that bit set, the interrupt stays pending.
- R4: With mode bit 1 set (clear-on-read), a read of address 0 clears a pending interrupt. With it clear, the read has no effect on the interrupt.
- R5: A write to address 1 loads the scan flag from bit 14 and the debounce field from bits 13:11. Writing the scan bit as 1 clears a pending interrupt. Writing it as 0 leaves the interrupt pending.
- R6: A read of address 1 returns the following, with all other bits 0:
  - the pending interrupt in bit 15;
  - in bit 14, the scan flag OR'ed with "no key held";
  - the debounce field in bits 13:11.
- R7: Address 2 holds the two mode bits in bits 15:14: bit 14 is mode bit 0 and bit 15 is mode bit 1. It reads back with all other bits 0. Address 3 holds the 16-bit mask, and a 1 excludes a key.
- R8: After reset:
  - the scan flag is 1 and the debounce field is 0;
  - the mask is all zeros and both mode bits are 1;
  - no interrupt is pending, `kbd_irq_n` is high and the bitmap is empty.
- R9: The interrupt is re-evaluated only on key events. A write to the mask or mode register alone neither sets nor clears it.
- R10: When a key event and a clearing register access happen in the same cycle, the clear acts first and the event rule then applies to the updated bitmap. A press that leaves an unmasked key held therefore keeps the interrupt set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | A key event is present this cycle |
| evt_idx | input | 4 | Index of the key for the event |
| evt_down | input | 1 | 1 for a press, 0 for a release |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; needed only for read side effects |
| reg_addr | input | 2 | Register select: 0 bitmap, 1 control, 2 mode, 3 mask |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `reg_addr`, combinational |
| kbd_irq_n | output | 1 | Keypad interrupt, active low |

## Verification
The hardest case to reach is the collision in R10: a clearing access and a key press in the same clock. The bench drives the read strobe and the press event on the same falling edge, with clear-on-read enabled and an interrupt already pending. It then compares the result with a plain acknowledging read. The other subtle case is a mask write that would change the outcome of the interrupt rule. To reach it, the bench first masks a held key, then unmasks it, and confirms the pin stays put until the next key event.

// File: rtl/kpic_pkg.sv
package kpic_pkg;

    typedef enum logic [1:0] {
        KP_REG_KEYS = 2'd0,
        KP_REG_CTRL = 2'd1,
        KP_REG_MODE = 2'd2,
        KP_REG_MASK = 2'd3
    } kp_reg_e;

    // Field positions in the control and mode registers
    localparam int unsigned KP_IRQ_BIT  = 15;
    localparam int unsigned KP_SCAN_BIT = 14;
    localparam int unsigned KP_DEB_LSB  = 11;
    localparam int unsigned KP_DEB_W    = 3;
    localparam int unsigned KP_MODE_LSB = 14;
    localparam int unsigned KP_MODE_W   = 2;

    // Mode bit meanings
    localparam int unsigned KP_MODE_HOLD = 0;
    localparam int unsigned KP_MODE_RDCLR = 1;

endpackage

// File: rtl/kp_key_tracker.sv
module kp_key_tracker #(
    parameter int unsigned NUM_KEYS = 16,
    localparam int unsigned IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    input  logic [IDX_W-1:0]    evt_idx,
    input  logic                evt_down,
    output logic [NUM_KEYS-1:0] held_d,
    output logic [NUM_KEYS-1:0] held_q
);

    typedef struct packed {
        logic [NUM_KEYS-1:0] held;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt_valid && (32'(evt_idx) < NUM_KEYS)) begin
            st_d.held[evt_idx] = evt_down;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_d = st_d.held;
    assign held_q = st_q.held;

    // R1
    press_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_down && (32'(evt_idx) < NUM_KEYS)) |=> held_q[$past(evt_idx)]);

    // R1
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_down && (32'(evt_idx) < NUM_KEYS)) |=> !held_q[$past(evt_idx)]);

endmodule

// File: rtl/kp_cfg_regs.sv
module kp_cfg_regs
    import kpic_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 16,
    parameter int unsigned DATA_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           reg_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic                 scan_q,
    output logic [KP_DEB_W-1:0]  deb_q,
    output logic [KP_MODE_W-1:0] mode_q,
    output logic [NUM_KEYS-1:0]  mask_q
);

    typedef struct packed {
        logic                 scan;
        logic [KP_DEB_W-1:0]  deb;
        logic [KP_MODE_W-1:0] mode;
        logic [NUM_KEYS-1:0]  mask;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (kp_reg_e'(reg_addr))
                KP_REG_CTRL: begin
                    st_d.scan = wr_data[KP_SCAN_BIT];
                    st_d.deb  = wr_data[KP_DEB_LSB +: KP_DEB_W];
                end
                KP_REG_MODE: st_d.mode = wr_data[KP_MODE_LSB +: KP_MODE_W];
                KP_REG_MASK: st_d.mask = wr_data[NUM_KEYS-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.scan <= 1'b1;
            st_q.deb  <= '0;
            st_q.mode <= '1;
            st_q.mask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_q = st_q.scan;
    assign deb_q  = st_q.deb;
    assign mode_q = st_q.mode;
    assign mask_q = st_q.mask;

    // R7
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kp_reg_e'(reg_addr) == KP_REG_MASK) |=> (mask_q == $past(wr_data[NUM_KEYS-1:0])));

endmodule

// File: rtl/kp_irq_ctrl.sv
module kp_irq_ctrl
    import kpic_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic                 evt_down,
    input  logic [NUM_KEYS-1:0]  held_d,
    input  logic [NUM_KEYS-1:0]  mask_q,
    input  logic [KP_MODE_W-1:0] mode_q,
    input  logic                 rd_ack,
    input  logic                 scan_ack,
    output logic                 irq_q
);

    typedef struct packed {
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic any_live;
    logic ack;

    assign any_live = |(held_d & ~mask_q);
    assign ack      = (rd_ack && mode_q[KP_MODE_RDCLR]) || scan_ack;

    always_comb begin
        st_d = st_q;
        // Clearing accesses act first; the key event rule follows.
        if (ack) st_d.irq = 1'b0;
        if (evt_valid) begin
            if (evt_down && any_live && !st_d.irq) begin
                st_d.irq = 1'b1;
            end else if (st_d.irq && !any_live && !mode_q[KP_MODE_HOLD]) begin
                st_d.irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_q = st_q.irq;

    // R2
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_down && any_live) |=> irq_q);

    // R3
    level_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !any_live && !mode_q[KP_MODE_HOLD]) |=> !irq_q);

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && mode_q[KP_MODE_RDCLR] && !evt_valid) |=> !irq_q);

    // R5
    scan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_ack && !evt_valid) |=> !irq_q);

    // R9
    rise_needs_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(evt_valid && evt_down));

endmodule

// File: rtl/keypad_irq_ctrl.sv
module keypad_irq_ctrl
    import kpic_pkg::*;
#(
    parameter int unsigned NUM_KEYS = 16,
    parameter int unsigned DATA_W   = 16,
    localparam int unsigned IDX_W   = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [IDX_W-1:0]  evt_idx,
    input  logic              evt_down,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              kbd_irq_n
);

    logic [NUM_KEYS-1:0]  held_d, held_q, mask_q;
    logic                 scan_q, irq_q;
    logic [KP_DEB_W-1:0]  deb_q;
    logic [KP_MODE_W-1:0] mode_q;
    logic                 rd_ack, scan_ack;

    assign rd_ack   = rd_en && (kp_reg_e'(reg_addr) == KP_REG_KEYS);
    assign scan_ack = wr_en && (kp_reg_e'(reg_addr) == KP_REG_CTRL) && wr_data[KP_SCAN_BIT];

    kp_key_tracker #(.NUM_KEYS(NUM_KEYS)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_idx   (evt_idx),
        .evt_down  (evt_down),
        .held_d    (held_d),
        .held_q    (held_q)
    );

    kp_cfg_regs #(.NUM_KEYS(NUM_KEYS), .DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .scan_q   (scan_q),
        .deb_q    (deb_q),
        .mode_q   (mode_q),
        .mask_q   (mask_q)
    );

    kp_irq_ctrl #(.NUM_KEYS(NUM_KEYS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_down  (evt_down),
        .held_d    (held_d),
        .mask_q    (mask_q),
        .mode_q    (mode_q),
        .rd_ack    (rd_ack),
        .scan_ack  (scan_ack),
        .irq_q     (irq_q)
    );

    always_comb begin
        rd_data = '0;
        unique case (kp_reg_e'(reg_addr))
            KP_REG_KEYS: rd_data[NUM_KEYS-1:0] = held_q;
            KP_REG_CTRL: begin
                rd_data[KP_IRQ_BIT]              = irq_q;
                rd_data[KP_SCAN_BIT]             = scan_q || (held_q == '0);
                rd_data[KP_DEB_LSB +: KP_DEB_W]  = deb_q;
            end
            KP_REG_MODE: rd_data[KP_MODE_LSB +: KP_MODE_W] = mode_q;
            KP_REG_MASK: rd_data[NUM_KEYS-1:0] = mask_q;
            default: ;
        endcase
    end

    assign kbd_irq_n = ~irq_q;

    // R8
    reset_pin_chk: assert property (@(posedge clk) $past(!rst_n) |-> kbd_irq_n);

endmodule

// File: tb/keypad_irq_ctrl_bench.sv
`timescale 1ns/1ps
module keypad_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [3:0]  evt_idx = '0;
    logic        evt_down = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        kbd_irq_n;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    keypad_irq_ctrl u_keypad_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx),
        .evt_down(evt_down), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .kbd_irq_n(kbd_irq_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic evt(input int idx, input bit down);
        @(negedge clk);
        evt_valid = 1'b1; evt_idx = 4'(idx); evt_down = down;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        apply_reset();
        check("R8 pin", 16'(kbd_irq_n), 16'h1);
        rd(2'd1, v); check("R8 ctrl", v, 16'h4000);
        rd(2'd2, v); check("R8 mode", v, 16'hC000);
        rd(2'd3, v); check("R8 mask", v, 16'h0000);
        rd(2'd0, v); check("R8 keys", v, 16'h0000);
    endtask

    task automatic t_level_mode();
        logic [15:0] v;
        wr(2'd2, 16'h0000);
        evt(3, 1'b1);
        check("R2 press raises", 16'(kbd_irq_n), 16'h0);
        rd(2'd0, v); check("R1 bitmap", v, 16'h0008);
        rd(2'd1, v); check("R6 ctrl pending", v, 16'hC000);
        evt(3, 1'b0);
        check("R3 release clears", 16'(kbd_irq_n), 16'h1);
        rd(2'd0, v); check("R1 release", v, 16'h0000);
    endtask

    task automatic t_hold_and_scan();
        logic [15:0] v;
        wr(2'd2, 16'h40FF);
        rd(2'd2, v); check("R7 mode readback", v, 16'h4000);
        evt(5, 1'b1);
        evt(5, 1'b0);
        check("R3 hold keeps", 16'(kbd_irq_n), 16'h0);
        rd(2'd0, v);
        check("R4 no clear on read", 16'(kbd_irq_n), 16'h0);
        wr(2'd1, 16'h6800);
        check("R5 scan write clears", 16'(kbd_irq_n), 16'h1);
        rd(2'd1, v); check("R5 R6 ctrl fields", v, 16'h6800);
        evt(2, 1'b1);
        wr(2'd1, 16'h1000);
        check("R5 scan0 keeps", 16'(kbd_irq_n), 16'h0);
        rd(2'd1, v); check("R6 scan0 key held", v, 16'h9000);
        evt(2, 1'b0);
        rd(2'd1, v); check("R6 scan0 no key", v, 16'hD000);
    endtask

    task automatic t_read_clear();
        logic [15:0] v;
        wr(2'd2, 16'hC000);
        check("R9 mode write no clear", 16'(kbd_irq_n), 16'h0);
        rd(2'd0, v);
        check("R4 read clears", 16'(kbd_irq_n), 16'h1);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(2'd2, 16'h0000);
        wr(2'd3, 16'h0001);
        rd(2'd3, v); check("R7 mask readback", v, 16'h0001);
        evt(0, 1'b1);
        check("R2 masked press", 16'(kbd_irq_n), 16'h1);
        wr(2'd3, 16'h0000);
        check("R9 unmask no raise", 16'(kbd_irq_n), 16'h1);
        evt(1, 1'b1);
        check("R2 unmasked press", 16'(kbd_irq_n), 16'h0);
        wr(2'd3, 16'hFFFF);
        check("R9 mask no clear", 16'(kbd_irq_n), 16'h0);
        evt(1, 1'b0);
        check("R3 all masked clears", 16'(kbd_irq_n), 16'h1);
        evt(0, 1'b0);
        wr(2'd0, 16'h1234);
        rd(2'd0, v); check("R1 keys write ignored", v, 16'h0000);
        wr(2'd3, 16'h0000);
    endtask

    task automatic t_same_cycle();
        logic [15:0] v;
        wr(2'd2, 16'hC000);
        evt(4, 1'b1);
        check("R2 pre", 16'(kbd_irq_n), 16'h0);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = 2'd0;
        evt_valid = 1'b1; evt_idx = 4'd6; evt_down = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; evt_valid = 1'b0;
        check("R10 press beats ack", 16'(kbd_irq_n), 16'h0);
        rd(2'd0, v);
        check("R10 bitmap", v, 16'h0050);
        check("R4 plain ack", 16'(kbd_irq_n), 16'h1);
        evt(4, 1'b0);
        evt(6, 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_level_mode();
        t_hold_and_scan();
        t_read_clear();
        t_mask();
        t_same_cycle();
        t_reset_state();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule